// File: doc/BRIEF.md
# Status-Polled Flash Bank Programmer

This block rewrites one bank of a byte-wide parallel flash that takes setup/confirm command pairs and reports progress through a status register. A single start pulse runs a fixed sequence. It erases the selected bank and checks that the bank reads blank. It then programs the bank one byte at a time from a source image, and finally reads the bank back against that same image. The flash sits in a two-bank window. Bank `b` occupies byte addresses `b*BANK_BYTES` to `(b+1)*BANK_BYTES-1`. The top address bit therefore selects the bank. All commands other than per-byte ones go to the bank base.

The image enters through a request/response stream. The block raises `src_ready_o` with the byte index it wants on `src_idx_o`. A byte is taken only in a cycle where `src_valid_i` and `src_ready_o` are both high. The source may hold `src_valid_i` low for as long as it likes. While it does, the block keeps `src_ready_o` high and keeps `src_idx_o` unchanged, and it issues nothing on the flash bus. The image is requested twice: once for programming and once for the readback compare. Both passes run from index 0 upward.

The flash bus is plain. A write happens in any cycle with `fl_we_o` high. A read happens in any cycle with `fl_oe_o` high, and `fl_rdata_i` must be valid within that same cycle. The status register reports ready in bit 7 (0x80), and bits 5..3 (0x38) are error bits. The wait between a program setup and its data write is computed from `CLK_HZ` and `WAIT_NS`. The result is called `WAIT_CYC` and is at least one cycle.

Top module: `flash_bank_prog`

## Requirements
- R1: After reset and whenever idle, `busy_o`, `done_o`, `timeout_o`, `vfail_o` and `err_o` are 0. No strobe is active and `src_ready_o` is 0.
- R2: A run begins with a write of 0x20 and then a write of 0xD0, both to the bank base address.
- R3: A status poll is a write of 0x70 to the bank base followed by a read of the bank base. The wait ends at the first read with bit 7 set. Until then, polls repeat back to back.
- R4: If POLL_LIMIT consecutive polls all read bit 7 clear, `timeout_o` is set and polling stops. No more than POLL_LIMIT base reads follow any command write.
- R5: Each erase phase and each program phase ends with a write of 0x50 and then a write of 0xFF to the bank base. This also holds after a timeout.
- R6: Erase verify reads the bank from offset 0 upward and expects 0xFF at every offset. On a mismatch, `vfail_o` is set, programming is skipped and the run ends.
- R7: Programming handles offsets 0 to BANK_BYTES-1 in ascending order. For each offset it writes 0x40 to the target address. It then lets at least WAIT_CYC idle cycles pass and writes the image byte to the same address. It then polls status.
- R8: A program poll timeout stops the program loop. The 0x50/0xFF pair is still issued, and program verify still runs.
- R9: Program verify compares each bank byte with the image byte of the same index. The first mismatch sets `vfail_o` and ends the run.
- R10: `err_o` is the OR of status bits 5..3 over every status read in the run. These bits do not affect the ready decision, `timeout_o` or `vfail_o`.
- R11: Image bytes move only on `src_valid_i && src_ready_o`. While the source stalls, `src_ready_o` stays high, `src_idx_o` holds and no flash write occurs. A full run takes 2*BANK_BYTES transfers.
- R12: `start_i` is ignored while `busy_o` is high. `done_o` rises at the end of a run and stays high until the next accepted start. An accepted start clears `done_o`, `timeout_o`, `vfail_o` and `err_o`.
- R13: Every flash access stays inside the bank latched at start. `fl_we_o` and `fl_oe_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when idle |
| bank_i | input | 1 | Bank to rewrite, sampled with an accepted start |
| src_ready_o | output | 1 | Block is asking for image byte `src_idx_o` |
| src_idx_o | output | $clog2(BANK_BYTES) | Index of the requested image byte |
| src_valid_i | input | 1 | Source presents the requested byte |
| src_data_i | input | 8 | Image byte |
| fl_addr_o | output | $clog2(2*BANK_BYTES) | Flash byte address |
| fl_wdata_o | output | 8 | Flash write data or command |
| fl_rdata_i | input | 8 | Flash read data, valid in the read cycle |
| fl_we_o | output | 1 | Write strobe, one write per high cycle |
| fl_oe_o | output | 1 | Read strobe, one read per high cycle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run finished; held until next start |
| timeout_o | output | 1 | A status wait exceeded POLL_LIMIT polls |
| vfail_o | output | 1 | Erase or program verify found a mismatch |
| err_o | output | 3 | Accumulated status error bits 5..3 |

## Verification
The hardest state to reach from the ports is a program timeout partway through the bank. That path needs a truncated loop, the cleanup pair, and a verify that fails exactly one byte past the stuck one. A second case of the same kind is a timeout on the last byte, which must still verify clean. The bench models the flash. The model can be told, per stimulus vector, to never report ready after a chosen byte, to corrupt one programmed byte, or to leave one erased byte non-blank. From the vector alone, the bench predicts the number of status reads, source transfers and cleanup pairs. A stalled source is held off at the program data step to show that the bus goes quiet while the requested index is held.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERS_ARM,
    ST_ERS_GO,
    ST_POLL_CMD,
    ST_POLL_RD,
    ST_CLR,
    ST_RST,
    ST_VFY,
    ST_PRG_ARM,
    ST_PRG_WAIT,
    ST_PRG_DATA
  } fbp_state_e;

  localparam logic [7:0] CMD_ERS_ARM = 8'h20;
  localparam logic [7:0] CMD_ERS_GO  = 8'hD0;
  localparam logic [7:0] CMD_PRG_ARM = 8'h40;
  localparam logic [7:0] CMD_STAT    = 8'h70;
  localparam logic [7:0] CMD_CLR     = 8'h50;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] BLANK_BYTE  = 8'hFF;
  localparam int         RDY_BIT     = 7;

endpackage

// File: rtl/fbp_limit_cnt.sv
module fbp_limit_cnt #(
  parameter int LIMIT = 4,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/fbp_verify.sv
module fbp_verify (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] got_i,
  input  logic [7:0] want_i,
  output logic       miss_o,
  output logic       fail_o
);

  logic fail_q;

  assign miss_o = en_i && (got_i != want_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fail_q <= 1'b0;
    else if (clr_i)  fail_q <= 1'b0;
    else if (miss_o) fail_q <= 1'b1;
  end

  assign fail_o = fail_q;

endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
  import fbp_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int POLL_LIMIT = 1000000,
  parameter int CLK_HZ     = 100000000,
  parameter int WAIT_NS    = 1000,
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int ADDR_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bank_i,
  output logic              src_ready_o,
  output logic [IDX_W-1:0]  src_idx_o,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i,
  output logic              fl_we_o,
  output logic              fl_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              vfail_o,
  output logic [2:0]        err_o
);

  localparam int WAIT_RAW = (CLK_HZ / 1000) * WAIT_NS / 1000000;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int PW       = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int WW       = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  fbp_state_e state_q, state_d;
  logic       bank_q, erase_ph_q, done_q, to_q;
  logic [2:0] err_q;

  logic idx_clr, idx_inc, idx_last;
  logic poll_clr, poll_inc, poll_last;
  logic wt_clr, wt_inc, wt_last;
  logic [IDX_W-1:0] idx;
  logic [PW-1:0]    poll_cnt;
  logic [WW-1:0]    wt_cnt;

  logic       start_go, vfy_en, vfy_miss, vfy_fail;
  logic [7:0] vfy_want;
  logic       rdy_seen;

  assign start_go = start_i && (state_q == ST_IDLE);
  assign rdy_seen = fl_rdata_i[RDY_BIT];

  fbp_limit_cnt #(.LIMIT(BANK_BYTES)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr_i(idx_clr), .inc_i(idx_inc),
    .cnt_o(idx), .last_o(idx_last));

  fbp_limit_cnt #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr_i(poll_clr), .inc_i(poll_inc),
    .cnt_o(poll_cnt), .last_o(poll_last));

  fbp_limit_cnt #(.LIMIT(WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr_i(wt_clr), .inc_i(wt_inc),
    .cnt_o(wt_cnt), .last_o(wt_last));

  assign vfy_en   = (state_q == ST_VFY) && (erase_ph_q || src_valid_i);
  assign vfy_want = erase_ph_q ? BLANK_BYTE : src_data_i;

  fbp_verify u_vfy (
    .clk(clk), .rst_n(rst_n), .clr_i(start_go), .en_i(vfy_en),
    .got_i(fl_rdata_i), .want_i(vfy_want), .miss_o(vfy_miss), .fail_o(vfy_fail));

  always_comb begin
    state_d     = state_q;
    fl_we_o     = 1'b0;
    fl_oe_o     = 1'b0;
    fl_addr_o   = {bank_q, {IDX_W{1'b0}}};
    fl_wdata_o  = 8'h00;
    src_ready_o = 1'b0;
    idx_clr = 1'b0; idx_inc = 1'b0;
    poll_clr = 1'b0; poll_inc = 1'b0;
    wt_clr = 1'b0; wt_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ERS_ARM;
      ST_ERS_ARM: begin
        fl_we_o = 1'b1; fl_wdata_o = CMD_ERS_ARM; state_d = ST_ERS_GO;
      end
      ST_ERS_GO: begin
        fl_we_o = 1'b1; fl_wdata_o = CMD_ERS_GO; poll_clr = 1'b1;
        state_d = ST_POLL_CMD;
      end
      ST_POLL_CMD: begin
        fl_we_o = 1'b1; fl_wdata_o = CMD_STAT; state_d = ST_POLL_RD;
      end
      ST_POLL_RD: begin
        fl_oe_o = 1'b1;
        if (rdy_seen) begin
          if (erase_ph_q || idx_last) state_d = ST_CLR;
          else begin
            idx_inc = 1'b1; state_d = ST_PRG_ARM;
          end
        end else if (poll_last) begin
          state_d = ST_CLR;
        end else begin
          poll_inc = 1'b1; state_d = ST_POLL_CMD;
        end
      end
      ST_CLR: begin
        fl_we_o = 1'b1; fl_wdata_o = CMD_CLR; state_d = ST_RST;
      end
      ST_RST: begin
        fl_we_o = 1'b1; fl_wdata_o = CMD_ARRAY; idx_clr = 1'b1;
        state_d = ST_VFY;
      end
      ST_VFY: begin
        fl_addr_o   = {bank_q, idx};
        src_ready_o = !erase_ph_q;
        if (vfy_en) begin
          fl_oe_o = 1'b1;
          if (vfy_miss) state_d = ST_IDLE;
          else if (idx_last) begin
            if (erase_ph_q) begin
              idx_clr = 1'b1; state_d = ST_PRG_ARM;
            end else state_d = ST_IDLE;
          end else idx_inc = 1'b1;
        end
      end
      ST_PRG_ARM: begin
        fl_addr_o = {bank_q, idx}; fl_we_o = 1'b1; fl_wdata_o = CMD_PRG_ARM;
        wt_clr = 1'b1; state_d = ST_PRG_WAIT;
      end
      ST_PRG_WAIT: begin
        wt_inc = 1'b1;
        if (wt_last) state_d = ST_PRG_DATA;
      end
      ST_PRG_DATA: begin
        fl_addr_o   = {bank_q, idx};
        src_ready_o = 1'b1;
        if (src_valid_i) begin
          fl_we_o = 1'b1; fl_wdata_o = src_data_i; poll_clr = 1'b1;
          state_d = ST_POLL_CMD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bank_q     <= 1'b0;
      erase_ph_q <= 1'b0;
      done_q     <= 1'b0;
      to_q       <= 1'b0;
      err_q      <= 3'b000;
    end else begin
      state_q <= state_d;
      if (start_go) begin
        bank_q     <= bank_i;
        erase_ph_q <= 1'b1;
        done_q     <= 1'b0;
        to_q       <= 1'b0;
        err_q      <= 3'b000;
      end
      if (state_q == ST_POLL_RD) begin
        err_q <= err_q | fl_rdata_i[5:3];
        if (!rdy_seen && poll_last) to_q <= 1'b1;
      end
      if (vfy_en && !vfy_miss && idx_last && erase_ph_q) erase_ph_q <= 1'b0;
      if (state_q != ST_IDLE && state_d == ST_IDLE) done_q <= 1'b1;
    end
  end

  assign src_idx_o = idx;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign vfail_o   = vfy_fail;
  assign err_o     = err_q;

endmodule

// File: rtl/flash_bank_prog_chk.sv
module flash_bank_prog_chk #(
  parameter int BANK_BYTES = 8192,
  parameter int POLL_LIMIT = 1000000,
  parameter int WAIT_CYC   = 100,
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int ADDR_W    = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              bank_i,
  input logic              src_ready_o,
  input logic [IDX_W-1:0]  src_idx_o,
  input logic              src_valid_i,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o,
  input logic              fl_we_o,
  input logic              fl_oe_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              vfail_o,
  input logic [2:0]        err_o
);

  logic bank_t;
  logic armed;
  int   gap;
  int   rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_t <= 1'b0;
      armed  <= 1'b0;
      gap    <= 0;
      rd_cnt <= 0;
    end else begin
      if (start_i && !busy_o) bank_t <= bank_i;
      if (fl_we_o) begin
        if (!armed && fl_wdata_o == 8'h40) begin
          armed <= 1'b1;
          gap   <= 1;
        end else if (armed) begin
          armed <= 1'b0;
        end
      end else if (armed && gap < WAIT_CYC + 1) begin
        gap <= gap + 1;
      end
      if (fl_we_o && fl_wdata_o != 8'h70) rd_cnt <= 0;
      else if (fl_oe_o && fl_addr_o[IDX_W-1:0] == '0 && rd_cnt <= POLL_LIMIT)
        rd_cnt <= rd_cnt + 1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !fl_we_o && !fl_oe_o && !src_ready_o); // R1

  AST_POLL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= POLL_LIMIT); // R4

  AST_ARM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    armed && fl_we_o |-> gap >= WAIT_CYC + 1); // R7

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o && !src_valid_i |=> src_ready_o && $stable(src_idx_o)); // R11

  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o && !src_valid_i |-> !fl_we_o); // R11

  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !done_o && !timeout_o && !vfail_o && err_o == 3'b000); // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R12

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o); // R12

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we_o && fl_oe_o)); // R13

  AST_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we_o || fl_oe_o) |-> fl_addr_o[ADDR_W-1] == bank_t); // R13

endmodule

bind flash_bank_prog flash_bank_prog_chk #(
  .BANK_BYTES(BANK_BYTES),
  .POLL_LIMIT(POLL_LIMIT),
  .WAIT_CYC(WAIT_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .bank_i(bank_i),
  .src_ready_o(src_ready_o), .src_idx_o(src_idx_o), .src_valid_i(src_valid_i),
  .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_we_o(fl_we_o),
  .fl_oe_o(fl_oe_o), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
  .vfail_o(vfail_o), .err_o(err_o)
);

// File: tb/flash_bank_prog_tb_top.sv
module flash_bank_prog_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BANK  = 16;
  localparam int PLIM  = 6;
  localparam int CLKHZ = 3000000;
  localparam int WNS   = 1000;
  localparam int WCYC  = 3;
  localparam int IW    = $clog2(BANK);
  localparam int AW    = IW + 1;
  localparam int WD    = 20000;

  typedef struct packed {
    logic       bank;
    logic [7:0] seed;
    logic [7:0] ers_polls;
    logic [7:0] prg_polls;
    logic       hang_e;
    logic [7:0] hang_p;
    logic [7:0] bad_e;
    logic [7:0] bad_p;
    logic [2:0] errb;
    logic       exp_to;
    logic       exp_vf;
  } vec_t;

  // 8'hFF in hang_p / bad_e / bad_p means "not used"
  localparam vec_t VECS [7] = '{
    '{1'b0, 8'h11, 8'd2, 8'd1, 1'b0, 8'hFF, 8'hFF, 8'hFF, 3'b000, 1'b0, 1'b0},
    '{1'b1, 8'h5A, 8'd0, 8'd3, 1'b0, 8'hFF, 8'hFF, 8'hFF, 3'b101, 1'b0, 1'b0},
    '{1'b0, 8'h33, 8'd1, 8'd0, 1'b1, 8'hFF, 8'hFF, 8'hFF, 3'b010, 1'b1, 1'b0},
    '{1'b1, 8'h44, 8'd1, 8'd0, 1'b0, 8'hFF, 8'd7,  8'hFF, 3'b000, 1'b0, 1'b1},
    '{1'b0, 8'h20, 8'd0, 8'd1, 1'b0, 8'd5,  8'hFF, 8'hFF, 3'b000, 1'b1, 1'b1},
    '{1'b1, 8'h66, 8'd0, 8'd0, 1'b0, 8'd15, 8'hFF, 8'hFF, 3'b000, 1'b1, 1'b0},
    '{1'b0, 8'h07, 8'd2, 8'd2, 1'b0, 8'hFF, 8'hFF, 8'd9,  3'b000, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          bank = 1'b0;
  logic          src_ready_o;
  logic [IW-1:0] src_idx_o;
  logic          src_valid;
  logic [7:0]    src_data;
  logic [AW-1:0] fl_addr_o;
  logic [7:0]    fl_wdata_o;
  logic [7:0]    fl_rdata;
  logic          fl_we_o, fl_oe_o, busy_o, done_o, timeout_o, vfail_o;
  logic [2:0]    err_o;

  int n_chk = 0;
  int n_err = 0;

  vec_t cur = VECS[0];
  logic mdl_init = 1'b0;
  logic hold_off = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bank_prog #(
    .BANK_BYTES(BANK), .POLL_LIMIT(PLIM), .CLK_HZ(CLKHZ), .WAIT_NS(WNS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bank_i(bank),
    .src_ready_o(src_ready_o), .src_idx_o(src_idx_o),
    .src_valid_i(src_valid), .src_data_i(src_data),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata),
    .fl_we_o(fl_we_o), .fl_oe_o(fl_oe_o), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o), .vfail_o(vfail_o), .err_o(err_o)
  );

  function automatic logic [7:0] img(input logic [7:0] seed, input int i);
    return 8'(i * 37) + seed;
  endfunction

  // ---------------- flash model ----------------
  logic [7:0] mem [2*BANK];
  logic       st_mode;
  logic [1:0] pend;
  int         polls_left;
  logic       hang;
  int         exp_idx, setup_cyc, cyc;
  logic [AW-1:0] setup_addr;
  logic [7:0] prev_wd;
  int n_stat_rd = 0, n_xfer = 0, n_pairs = 0, n_proto = 0, n_wr = 0;

  always_comb begin
    if (st_mode) fl_rdata = {(!hang && polls_left == 0), 1'b0, cur.errb, 3'b000};
    else         fl_rdata = mem[fl_addr_o];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mdl_init) begin
      for (int i = 0; i < 2*BANK; i++) mem[i] <= 8'h3C;
      st_mode <= 1'b0; pend <= 2'd0; polls_left <= 0; hang <= 1'b0;
      exp_idx <= 0; prev_wd <= 8'h00;
    end else begin
      if (fl_oe_o && st_mode) begin
        n_stat_rd <= n_stat_rd + 1;
        if (polls_left > 0) polls_left <= polls_left - 1;
      end
      if (src_ready_o && src_valid) n_xfer <= n_xfer + 1;
      if ((fl_we_o || fl_oe_o) && fl_addr_o[AW-1] != cur.bank) n_proto <= n_proto + 1;
      if (fl_we_o) begin
        n_wr <= n_wr + 1;
        prev_wd <= fl_wdata_o;
        if (pend == 2'd2) begin
          if (fl_addr_o != setup_addr || (cyc - setup_cyc) < WCYC + 1 ||
              int'(fl_addr_o[IW-1:0]) != exp_idx)
            n_proto <= n_proto + 1;
          if (8'(fl_addr_o[IW-1:0]) == cur.bad_p) mem[fl_addr_o] <= fl_wdata_o ^ 8'h01;
          else mem[fl_addr_o] <= mem[fl_addr_o] & fl_wdata_o;
          exp_idx <= exp_idx + 1;
          polls_left <= int'(cur.prg_polls);
          hang <= (8'(fl_addr_o[IW-1:0]) == cur.hang_p);
          st_mode <= 1'b1; pend <= 2'd0;
        end else begin
          case (fl_wdata_o)
            8'h20: begin
              pend <= 2'd1;
              if (fl_addr_o[IW-1:0] != '0) n_proto <= n_proto + 1;
            end
            8'hD0: begin
              if (pend != 2'd1 || fl_addr_o[IW-1:0] != '0) n_proto <= n_proto + 1;
              for (int i = 0; i < BANK; i++)
                mem[{cur.bank, IW'(i)}] <= (8'(i) == cur.bad_e) ? 8'h00 : 8'hFF;
              polls_left <= int'(cur.ers_polls); hang <= cur.hang_e;
              st_mode <= 1'b1; pend <= 2'd0;
            end
            8'h40: begin pend <= 2'd2; setup_addr <= fl_addr_o; setup_cyc <= cyc; end
            8'h70: begin
              st_mode <= 1'b1;
              if (fl_addr_o[IW-1:0] != '0) n_proto <= n_proto + 1;
            end
            8'h50: if (fl_addr_o[IW-1:0] != '0) n_proto <= n_proto + 1;
            8'hFF: begin
              st_mode <= 1'b0; pend <= 2'd0;
              if (prev_wd == 8'h50) n_pairs <= n_pairs + 1;
            end
            default: n_proto <= n_proto + 1;
          endcase
        end
      end
    end
  end

  // ---------------- image source ----------------
  always @(negedge clk) begin
    src_valid = !hold_off && (((cyc * 7 + int'(cur.seed)) % 3) != 0);
  end
  assign src_data = img(cur.seed, int'(src_idx_o));

  // ---------------- checking ----------------
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_xfer(input vec_t v);
    int k;
    if (v.bad_e != 8'hFF) return 0;
    if (v.hang_p != 8'hFF) begin
      k = int'(v.hang_p);
      if (k == BANK - 1) return 2 * BANK;
      return (k + 1) + (k + 2);
    end
    if (v.bad_p != 8'hFF) return BANK + int'(v.bad_p) + 1;
    return 2 * BANK;
  endfunction

  function automatic int exp_stat(input vec_t v);
    int e;
    e = v.hang_e ? PLIM : int'(v.ers_polls) + 1;
    if (v.bad_e != 8'hFF) return e;
    if (v.hang_p != 8'hFF) return e + int'(v.hang_p) * (int'(v.prg_polls) + 1) + PLIM;
    return e + BANK * (int'(v.prg_polls) + 1);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done(output bit hung);
    hung = 1'b1;
    for (int t = 0; t < WD; t++) begin
      if (done_o) begin hung = 1'b0; break; end
      @(negedge clk);
    end
    if (hung) begin
      chk("R12 watchdog expired", 0, 1);
      do_reset();
    end
  endtask

  task automatic run(input vec_t v, input int poke, input string name);
    int s_stat, s_xfer, s_pair, s_proto;
    bit hung;
    cur = v;
    mdl_init = 1'b1; @(negedge clk); mdl_init = 1'b0;
    s_stat = n_stat_rd; s_xfer = n_xfer; s_pair = n_pairs; s_proto = n_proto;
    start = 1'b1; bank = v.bank; @(negedge clk); start = 1'b0;
    hung = 1'b1;
    for (int t = 0; t < WD; t++) begin
      if (done_o) begin hung = 1'b0; break; end
      start = (t == poke);
      bank  = (t == poke) ? ~v.bank : v.bank;
      @(negedge clk);
    end
    start = 1'b0;
    if (hung) begin
      chk({"R12 watchdog ", name}, 0, 1);
      do_reset();
    end
    chk({"R12 done ", name}, int'(done_o), 1);
    chk({"R4/R8 timeout ", name}, int'(timeout_o), int'(v.exp_to));
    chk({"R6/R9 vfail ", name}, int'(vfail_o), int'(v.exp_vf));
    chk({"R10 err bits ", name}, int'(err_o), int'(v.errb));
    chk({"R3/R4 status reads ", name}, n_stat_rd - s_stat, exp_stat(v));
    chk({"R11 transfers ", name}, n_xfer - s_xfer, exp_xfer(v));
    chk({"R5 clear/reset pairs ", name}, n_pairs - s_pair, (v.bad_e != 8'hFF) ? 1 : 2);
    chk({"R2/R7/R13 bus protocol ", name}, n_proto - s_proto, 0);
  endtask

  initial begin
    int t_idx, t_wr;
    bit hung;

    repeat (2) @(negedge clk);
    // R1: state while held in reset and right after release
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 strobes in reset", int'(fl_we_o | fl_oe_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 flags after reset", int'({timeout_o, vfail_o, err_o}), 0);
    chk("R1 src_ready after reset", int'(src_ready_o), 0);

    // table walk
    for (int i = 0; i < 7; i++) run(VECS[i], -1, $sformatf("vec%0d", i));

    // R12: start pulse with the other bank in mid-run is ignored
    run(VECS[0], 30, "busy start");

    // R12: done holds, next start clears it
    repeat (5) @(negedge clk);
    chk("R12 done held", int'(done_o), 1);

    // R11: stalled source at program data step
    cur = VECS[1];
    mdl_init = 1'b1; @(negedge clk); mdl_init = 1'b0;
    hold_off = 1'b1;
    @(negedge clk);
    start = 1'b1; bank = VECS[1].bank; @(negedge clk); start = 1'b0;
    chk("R12 start clears done", int'(done_o), 0);
    chk("R12 busy after start", int'(busy_o), 1);
    for (int t = 0; t < WD && !src_ready_o; t++) @(negedge clk);
    t_idx = int'(src_idx_o); t_wr = n_wr;
    repeat (20) @(negedge clk);
    chk("R11 ready held in stall", int'(src_ready_o), 1);
    chk("R11 index held in stall", int'(src_idx_o), t_idx);
    chk("R11 no write in stall", n_wr - t_wr, 0);
    hold_off = 1'b0;
    wait_done(hung);
    chk("R11 stall run vfail", int'(vfail_o), 0);
    chk("R11 stall run timeout", int'(timeout_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule